// File: doc/BRIEF.md
# Tiled Matrix Multiply Engine

This block multiplies two square matrices, P = M × N, of side `WIDTH`. All three matrices sit in on-chip memories outside the block and are stored row-major, so element (row, col) lives at address `row*WIDTH + col`. A one-cycle `start` pulse launches a full product. The engine then reads operands through two synchronous read ports and writes each finished result through one write port. A single-cycle `done` marks the end of the product.

The output is processed one square tile of `TILE_WIDTH × TILE_WIDTH` elements at a time, and there are (`WIDTH/TILE_WIDTH`)² tiles. Each output element is found from its tile coordinate and its position inside the tile. Its accumulator is cleared, one multiply-accumulate runs per k, and the unsigned sum is written out. Operands are never reused between elements, so every M and N entry is fetched once for each output element that needs it.

Top module: `tile_matmul`

## Requirements
- R1: While reset is asserted and while the engine is idle after reset, `busy`, `done`, `rdEn` and `pWrEn` are all 0.
- R2: Each write puts at address `row*WIDTH+col` the value of the sum over k of M[row*WIDTH+k]·N[k*WIDTH+col]. Operands are unsigned, and the sum starts from zero for every element, including the first element of a new run.
- R3: The result is exact for every operand value. With all operands at their maximum 2^DATA_W−1, every result equals WIDTH·(2^DATA_W−1)².
- R4: Results are written in this order. Tiles go with tile column fastest, then tile row. Inside a tile, local column is fastest, then local row. Row = tileRow·TILE_WIDTH+localRow and column = tileCol·TILE_WIDTH+localCol. Exactly WIDTH² writes occur per run.
- R5: Each element's operands are read on WIDTH consecutive cycles with k ascending. `mAddr` steps by 1 and `nAddr` steps by WIDTH. The write of that element occurs two cycles after its last read cycle, with no read in between.
- R6: During one run, every M address and every N address is read exactly WIDTH times.
- R7: `done` is high for exactly one cycle, the cycle right after the last write of a run.
- R8: A `start` seen while idle raises `busy` on the next cycle. A `start` seen while `busy` is high has no effect: the write sequence and the single `done` are unchanged, and the engine stays idle after `done`.
- R9: Read data is taken from `mData`/`nData` one cycle after the cycle in which `rdEn` and the addresses were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a product when idle |
| busy | output | 1 | A product is in progress |
| done | output | 1 | One-cycle end-of-product pulse |
| rdEn | output | 1 | Read strobe for both operand memories |
| mAddr | output | AW | Address into M |
| nAddr | output | AW | Address into N |
| mData | input | DATA_W | M read data, valid one cycle after rdEn |
| nData | input | DATA_W | N read data, valid one cycle after rdEn |
| pWrEn | output | 1 | Write strobe into P |
| pAddr | output | AW | Address into P |
| pData | output | ACC_W | Result written into P |

## Verification
The bench runs an all-maximum run straight after a run with nonzero results. A design that carried the accumulator over, or whose sum was too narrow, writes a wrong first or any value. Each write address is compared against a scoreboard built in tile order, so a plain row-by-row scan, or a swapped tile and local index, shows up as an address mismatch. Extra `start` pulses are sent mid-run and `start` is held through a whole run. A restart shows up as excess writes, a second `done`, or `busy` after `done`. Per-address read counts and the read-to-write spacing catch skipped or repeated k steps and a wrong read-latency assumption.

// File: rtl/tm_pkg.sv
package tm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_FLUSH,
    ST_STORE,
    ST_FINISH
  } tmState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accClear;
    logic readEn;
    logic store;
  } tmStrobe_t;

endpackage

// File: rtl/tm_ctrl.sv
module tm_ctrl
  import tm_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int TILE_WIDTH = 2,
  parameter int CW         = 2,
  parameter int TW         = 1,
  parameter int LW         = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output tmStrobe_t     strb,
  output logic          busy,
  output logic          done,
  output logic [TW-1:0] tileX,
  output logic [TW-1:0] tileY,
  output logic [LW-1:0] locX,
  output logic [LW-1:0] locY,
  output logic [CW-1:0] kIdx
);

  localparam int NT = WIDTH / TILE_WIDTH;

  tmState_e state, stateNxt;
  logic kLast, locXLast, locYLast, tileXLast, tileYLast, allLast;

  assign kLast     = (kIdx  == CW'(WIDTH - 1));
  assign locXLast  = (locX  == LW'(TILE_WIDTH - 1));
  assign locYLast  = (locY  == LW'(TILE_WIDTH - 1));
  assign tileXLast = (tileX == TW'(NT - 1));
  assign tileYLast = (tileY == TW'(NT - 1));
  assign allLast   = locXLast && locYLast && tileXLast && tileYLast;

  always_comb begin
    stateNxt      = state;
    strb.accClear = 1'b0;
    strb.readEn   = 1'b0;
    strb.store    = 1'b0;
    unique case (state)
      ST_IDLE:   if (start) stateNxt = ST_READ;
      ST_READ: begin
        strb.readEn   = 1'b1;
        strb.accClear = (kIdx == '0);
        if (kLast) stateNxt = ST_FLUSH;
      end
      ST_FLUSH:  stateNxt = ST_STORE;
      ST_STORE: begin
        strb.store = 1'b1;
        stateNxt   = allLast ? ST_FINISH : ST_READ;
      end
      ST_FINISH: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kIdx  <= '0;
      locX  <= '0;
      locY  <= '0;
      tileX <= '0;
      tileY <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_READ) begin
        kIdx <= kLast ? '0 : kIdx + 1'b1;
      end
      if (state == ST_STORE) begin
        if (!locXLast) locX <= locX + 1'b1;
        else begin
          locX <= '0;
          if (!locYLast) locY <= locY + 1'b1;
          else begin
            locY <= '0;
            if (!tileXLast) tileX <= tileX + 1'b1;
            else begin
              tileX <= '0;
              tileY <= tileYLast ? '0 : tileY + 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/tm_addr.sv
module tm_addr #(
  parameter int WIDTH      = 4,
  parameter int TILE_WIDTH = 2,
  parameter int CW         = 2,
  parameter int TW         = 1,
  parameter int LW         = 1,
  parameter int AW         = 4
) (
  input  logic [TW-1:0] tileX,
  input  logic [TW-1:0] tileY,
  input  logic [LW-1:0] locX,
  input  logic [LW-1:0] locY,
  input  logic [CW-1:0] kIdx,
  output logic [AW-1:0] mAddr,
  output logic [AW-1:0] nAddr,
  output logic [AW-1:0] pAddr
);

  logic [CW-1:0] rowIdx, colIdx;

  assign rowIdx = CW'(CW'(tileY) * CW'(TILE_WIDTH) + CW'(locY));
  assign colIdx = CW'(CW'(tileX) * CW'(TILE_WIDTH) + CW'(locX));

  assign mAddr = AW'(AW'(rowIdx) * AW'(WIDTH) + AW'(kIdx));
  assign nAddr = AW'(AW'(kIdx)   * AW'(WIDTH) + AW'(colIdx));
  assign pAddr = AW'(AW'(rowIdx) * AW'(WIDTH) + AW'(colIdx));

endmodule

// File: rtl/tm_dp.sv
module tm_dp
  import tm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmStrobe_t         strb,
  input  logic [DATA_W-1:0] mData,
  input  logic [DATA_W-1:0] nData,
  output logic [ACC_W-1:0]  pData
);

  logic             validQ;
  logic [ACC_W-1:0] acc, prod;

  assign prod = ACC_W'(mData) * ACC_W'(nData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      acc    <= '0;
    end else begin
      validQ <= strb.readEn;
      if (strb.accClear)  acc <= '0;
      else if (validQ)    acc <= acc + prod;
    end
  end

  assign pData = strb.store ? acc : '0;

endmodule

// File: rtl/tile_matmul.sv
module tile_matmul
  import tm_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int TILE_WIDTH = 2,
  parameter int DATA_W     = 8,
  localparam int CW    = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int AW    = (WIDTH > 1) ? $clog2(WIDTH * WIDTH) : 1,
  localparam int ACC_W = 2 * DATA_W + CW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              rdEn,
  output logic [AW-1:0]     mAddr,
  output logic [AW-1:0]     nAddr,
  input  logic [DATA_W-1:0] mData,
  input  logic [DATA_W-1:0] nData,
  output logic              pWrEn,
  output logic [AW-1:0]     pAddr,
  output logic [ACC_W-1:0]  pData
);

  localparam int NT = WIDTH / TILE_WIDTH;
  localparam int TW = (NT > 1) ? $clog2(NT) : 1;
  localparam int LW = (TILE_WIDTH > 1) ? $clog2(TILE_WIDTH) : 1;

  if ((WIDTH % TILE_WIDTH) != 0 || TILE_WIDTH < 1) begin : gBadTile
    $error("WIDTH must be a multiple of TILE_WIDTH");
  end

  tmStrobe_t     strb;
  logic [TW-1:0] tileX, tileY;
  logic [LW-1:0] locX, locY;
  logic [CW-1:0] kIdx;

  tm_ctrl #(
    .WIDTH(WIDTH), .TILE_WIDTH(TILE_WIDTH), .CW(CW), .TW(TW), .LW(LW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb),
    .busy(busy), .done(done),
    .tileX(tileX), .tileY(tileY), .locX(locX), .locY(locY), .kIdx(kIdx)
  );

  tm_addr #(
    .WIDTH(WIDTH), .TILE_WIDTH(TILE_WIDTH), .CW(CW), .TW(TW), .LW(LW), .AW(AW)
  ) uAddr (
    .tileX(tileX), .tileY(tileY), .locX(locX), .locY(locY), .kIdx(kIdx),
    .mAddr(mAddr), .nAddr(nAddr), .pAddr(pAddr)
  );

  tm_dp #(.DATA_W(DATA_W), .ACC_W(ACC_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .mData(mData), .nData(nData), .pData(pData)
  );

  assign rdEn  = strb.readEn;
  assign pWrEn = strb.store;

endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int WIDTH = 4,
  parameter int AW    = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rdEn,
  input logic [AW-1:0] mAddr,
  input logic [AW-1:0] nAddr,
  input logic          pWrEn
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdEn && !pWrEn && !done));

  assert_m_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn)) |-> (mAddr == AW'($past(mAddr) + 1'b1)));

  assert_n_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn)) |-> (nAddr == AW'($past(nAddr) + AW'(WIDTH))));

  assert_write_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    pWrEn |-> (!rdEn && !$past(rdEn) && $past(rdEn, 2)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(pWrEn));

  assert_start_launch_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

endmodule

bind tile_matmul tm_checker #(.WIDTH(WIDTH), .AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .rdEn(rdEn), .mAddr(mAddr), .nAddr(nAddr), .pWrEn(pWrEn)
);

// File: tb/sim_tile_matmul.sv
`timescale 1ns/1ps
module sim_tile_matmul;

  localparam int W     = 4;
  localparam int T     = 2;
  localparam int D     = 8;
  localparam int AW    = 4;
  localparam int ACC_W = 2 * D + 2;
  localparam int NE    = W * W;

  typedef struct {
    int      addr;
    longint  val;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, rdEn, pWrEn;
  logic [AW-1:0] mAddr, nAddr, pAddr;
  logic [D-1:0] mData = '0, nData = '0;
  logic [ACC_W-1:0] pData;

  int nChecks = 0, nFails = 0;
  int wrCount = 0;
  int cycles = 0;
  int rdCntM [NE];
  int rdCntN [NE];
  int mMem [NE];
  int nMem [NE];
  expItem_t expQ [$];
  int seed = 7;

  always #4 clk = ~clk;

  tile_matmul #(.WIDTH(W), .TILE_WIDTH(T), .DATA_W(D)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .rdEn(rdEn), .mAddr(mAddr), .nAddr(nAddr), .mData(mData), .nData(nData),
    .pWrEn(pWrEn), .pAddr(pAddr), .pData(pData)
  );

  initial begin
    for (int i = 0; i < NE; i++) begin
      rdCntM[i] = 0;
      rdCntN[i] = 0;
      mMem[i] = 0;
      nMem[i] = 0;
    end
  end

  // memory model: data one cycle after the read strobe (R9)
  always @(posedge clk) begin
    if (rdEn) begin
      mData <= D'(mMem[mAddr]);
      nData <= D'(nMem[nAddr]);
      rdCntM[mAddr] = rdCntM[mAddr] + 1;
      rdCntN[nAddr] = rdCntN[nAddr] + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit prevRd = 0;
  int curRun = 0, lastRun = 0, sinceRd = 99;
  always @(negedge clk) begin
    if (rstN) begin
      if (rdEn) begin
        curRun  = prevRd ? curRun + 1 : 1;
        sinceRd = 0;
      end else begin
        if (prevRd) lastRun = curRun;
        sinceRd++;
      end
      prevRd = rdEn;
      if (pWrEn) begin
        wrCount++;
        check(sinceRd == 2, "R5 read-to-write gap", sinceRd, 2);
        check(lastRun == W, "R5 read run length", lastRun, W);
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected write", pAddr, -1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(int'(pAddr) == e.addr, "R4 write address order", pAddr, e.addr);
          check(longint'(pData) == e.val, "R2/R3/R9 result value", pData, e.val);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 255;
  endfunction

  task automatic fillPattern(input int pat);
    for (int i = 0; i < NE; i++) begin
      case (pat)
        0: begin mMem[i] = i + 1; nMem[i] = (i % 5) + 2; end
        1: begin mMem[i] = 255; nMem[i] = 255; end
        2: begin mMem[i] = (i == 11) ? 7 : 0; nMem[i] = ((i / W) == (i % W)) ? 3 : 0; end
        default: begin mMem[i] = nextRand(); nMem[i] = nextRand(); end
      endcase
    end
  endtask

  // driver: builds the expected sequence in tile order, then launches
  task automatic runJob(input int pat, input bit holdStart, input bit pokeStart);
    int baseM [NE];
    int baseN [NE];
    int wrBase, guard, dones;
    fillPattern(pat);
    for (int ty = 0; ty < W / T; ty++)
      for (int tx = 0; tx < W / T; tx++)
        for (int ly = 0; ly < T; ly++)
          for (int lx = 0; lx < T; lx++) begin
            expItem_t e;
            int row, col;
            longint s;
            row = ty * T + ly;
            col = tx * T + lx;
            s = 0;
            for (int k = 0; k < W; k++) s += longint'(mMem[row * W + k]) * longint'(nMem[k * W + col]);
            e.addr = row * W + col;
            e.val  = s;
            expQ.push_back(e);
          end
    for (int i = 0; i < NE; i++) begin
      baseM[i] = rdCntM[i];
      baseN[i] = rdCntN[i];
    end
    wrBase = wrCount;
    dones = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    if (!holdStart) start = 1'b0;
    if (pokeStart) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (done) dones++;
    end
    start = 1'b0;
    check(dones == 1, "R7 done seen once", dones, 1);
    check(wrCount - wrBase == NE, "R7 writes before done", wrCount - wrBase, NE);
    check(expQ.size() == 0, "R4 all results written", expQ.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", done, 0);
    for (int c = 0; c < 4; c++) begin
      check(busy == 1'b0 && pWrEn == 1'b0, "R8 idle after done", busy, 0);
      @(negedge clk);
    end
    for (int i = 0; i < NE; i++) begin
      check(rdCntM[i] - baseM[i] == W, "R6 M reads per address", rdCntM[i] - baseM[i], W);
      check(rdCntN[i] - baseN[i] == W, "R6 N reads per address", rdCntN[i] - baseN[i], W);
    end
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rdEn && !pWrEn, "R1 outputs during reset", {busy, done, rdEn, pWrEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !rdEn && !pWrEn, "R1 outputs idle after reset", {busy, done, rdEn, pWrEn}, 0);
    runJob(0, 1'b0, 1'b0);   // R2 R4 ordered pattern
    runJob(1, 1'b0, 1'b0);   // R3 all-maximum operands
    runJob(2, 1'b0, 1'b0);   // R2 accumulator cleared after large run
    runJob(3, 1'b0, 1'b1);   // R8 extra start pulses mid-run
    runJob(3, 1'b1, 1'b0);   // R8 start held through the run
    runJob(3, 1'b0, 1'b0);   // R9 random data
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule